// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the programmed set-up of a single DMA channel and walks it through a transfer one beat at a time. Software loads two base addresses, an item count and a mode word. The mode word holds the direction, the element width of each side, the per-side increment enables, the circular flag and the memory-to-memory flag. A start strobe then launches the channel. While the channel runs, the block presents the read-side and write-side addresses and widths for the next beat. It raises a beat request when the beat may proceed, and advances its working pointers and remaining count each time the outside world reports that a beat has finished.

The stored base addresses and count are never modified by the transfer. Separate working pointers and a separate remaining counter are loaded from them at start, and again at each wrap in circular mode. Memory-to-memory transfers need no peripheral request. A channel configured for both circular and memory-to-memory operation refuses to start and flags a configuration error. The bus master, arbitration, interrupt delivery and data movement sit outside this block. A single beat-done strobe represents all of them.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `busy`, `xfer_done`, `cfg_err` and `beat_req` are 0.
- R2: A `start` while idle, with a non-zero stored count and a legal mode, sets `busy` on the next cycle. It loads the working pointers with the stored bases and `remaining` with the stored count. A `start` while busy is ignored.
- R3: Each accepted beat lowers `remaining` by exactly one, except the last beat of a transfer.
- R4: On an accepted beat, a side whose increment enable is 1 advances its pointer by its element width in bytes: width code 0 is 1 byte, code 1 is 2 bytes, codes 2 and 3 are 4 bytes. A side whose increment enable is 0 keeps its address.
- R5: With direction 0 (memory to peripheral), `src_addr`/`src_width` are the memory pointer and memory width, and `dst_addr`/`dst_width` are the peripheral pointer and peripheral width. With direction 1 (peripheral to memory), the two sides swap.
- R6: `beat_req` equals `busy` AND (memory-to-memory flag OR `per_req`). A `beat_done` while `beat_req` is 0 changes nothing.
- R7: Outside circular mode, the accepted beat taken when `remaining` is 1 produces a one-cycle `xfer_done` pulse, and `busy` clears on the same edge.
- R8: In circular mode, that last beat pulses `xfer_done` and reloads `remaining` and both pointers from the stored values, and `busy` stays 1.
- R9: A `start` while idle with both circular and memory-to-memory set leaves `busy` at 0 and sets `cfg_err`. `cfg_err` clears on the next successful start.
- R10: With a stored count of 0, `start` never sets `busy`, so no beat is requested and `xfer_done` never pulses.
- R11: A `cfg_wr` while busy is ignored. The stored bases and count stay unchanged, and a later restart reloads the earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Store the cfg_* inputs (only while idle) |
| cfg_per_base | input | AW | Peripheral base address |
| cfg_mem_base | input | AW | Memory base address |
| cfg_count | input | CW | Items per transfer |
| cfg_dir | input | 1 | 0 = memory to peripheral, 1 = peripheral to memory |
| cfg_per_width | input | 2 | Peripheral element width code |
| cfg_mem_width | input | 2 | Memory element width code |
| cfg_per_inc | input | 1 | Peripheral pointer increments |
| cfg_mem_inc | input | 1 | Memory pointer increments |
| cfg_circ | input | 1 | Circular mode |
| cfg_m2m | input | 1 | Memory-to-memory mode |
| start | input | 1 | Enable strobe, uses the stored set-up |
| per_req | input | 1 | Peripheral request |
| beat_done | input | 1 | Current beat finished |
| busy | output | 1 | Channel enabled |
| beat_req | output | 1 | A beat may proceed |
| src_addr | output | AW | Read-side address of the current beat |
| dst_addr | output | AW | Write-side address of the current beat |
| src_width | output | 2 | Read-side width code |
| dst_width | output | 2 | Write-side width code |
| remaining | output | CW | Items left in this pass |
| xfer_done | output | 1 | One-cycle pass-complete pulse |
| cfg_err | output | 1 | Illegal mode combination at start |

## Verification
The assertions assume that `cfg_wr` and `start` never arrive in the same cycle. They also assume that reset is held for at least two clock edges, so the pointer and counter step checks never look back to undefined values. The stimulus drives all inputs on the falling edge and issues `cfg_wr` and `start` in separate cycles. It draws random widths, increment enables, directions, request and beat-done patterns from a fixed seed. Circular runs are ended by a reset pulse, so the stimulus never needs to stop a running channel any other way.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic {
        DIR_MEM_TO_PER = 1'b0,
        DIR_PER_TO_MEM = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        xfer_dir_e  dir;
        logic [1:0] per_width;
        logic [1:0] mem_width;
        logic       per_inc;
        logic       mem_inc;
        logic       circ;
        logic       m2m;
    } chan_mode_t;

    // Width code to byte step: 0 -> 1, 1 -> 2, 2/3 -> 4
    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd0:    width_bytes = 3'd1;
            2'd1:    width_bytes = 3'd2;
            default: width_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    input  logic          inc,
    input  logic [1:0]    width,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] step_bytes;

    assign step_bytes = AW'(width_bytes(width));

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= base;
        else if (step && inc)
            ptr <= ptr + step_bytes;
    end

    // R4: an incrementing step adds the element width in bytes
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (step && inc && !load) |=> (ptr == $past(ptr) + $past(step_bytes)));

    // R4: without increment the pointer holds
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (step && !inc && !load) |=> $stable(ptr));

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] rem,
    output logic          last
);
    assign last = (rem == CW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            rem <= '0;
        else if (load)
            rem <= load_val;
        else if (dec)
            rem <= rem - CW'(1);
    end

    // R3: a non-final accepted beat lowers the count by one
    a_r3_dec_one: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |=> (rem == $past(rem) - CW'(1)));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [AW-1:0] cfg_per_base,
    input  logic [AW-1:0] cfg_mem_base,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_dir,
    input  logic [1:0]    cfg_per_width,
    input  logic [1:0]    cfg_mem_width,
    input  logic          cfg_per_inc,
    input  logic          cfg_mem_inc,
    input  logic          cfg_circ,
    input  logic          cfg_m2m,
    input  logic          start,
    input  logic          per_req,
    input  logic          beat_done,
    output logic          busy,
    output logic          beat_req,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [1:0]    src_width,
    output logic [1:0]    dst_width,
    output logic [CW-1:0] remaining,
    output logic          xfer_done,
    output logic          cfg_err
);
    localparam int NSIDE = 2;   // index 0 = peripheral, 1 = memory

    chan_mode_t    mode_q;
    logic [AW-1:0] per_base_q, mem_base_q;
    logic [CW-1:0] count_q;

    logic          mode_bad, start_ok, accept, last, wrap, reload;
    logic [AW-1:0] side_base [NSIDE];
    logic [AW-1:0] side_ptr  [NSIDE];
    logic [1:0]    side_w    [NSIDE];
    logic          side_inc  [NSIDE];

    // stored set-up: written only while idle
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            per_base_q <= '0;
            mem_base_q <= '0;
            count_q    <= '0;
        end else if (cfg_wr && !busy) begin
            mode_q.dir       <= xfer_dir_e'(cfg_dir);
            mode_q.per_width <= cfg_per_width;
            mode_q.mem_width <= cfg_mem_width;
            mode_q.per_inc   <= cfg_per_inc;
            mode_q.mem_inc   <= cfg_mem_inc;
            mode_q.circ      <= cfg_circ;
            mode_q.m2m       <= cfg_m2m;
            per_base_q       <= cfg_per_base;
            mem_base_q       <= cfg_mem_base;
            count_q          <= cfg_count;
        end
    end

    assign mode_bad = mode_q.circ && mode_q.m2m;
    assign start_ok = start && !busy && !mode_bad && (count_q != '0);
    assign beat_req = busy && (mode_q.m2m || per_req);
    assign accept   = beat_req && beat_done;
    assign wrap     = accept && last && mode_q.circ;
    assign reload   = start_ok || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            xfer_done <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            xfer_done <= accept && last;
            if (start_ok) begin
                busy    <= 1'b1;
                cfg_err <= 1'b0;
            end else if (start && !busy && mode_bad) begin
                cfg_err <= 1'b1;
            end else if (accept && last && !mode_q.circ) begin
                busy    <= 1'b0;
            end
        end
    end

    assign side_base[0] = per_base_q;
    assign side_base[1] = mem_base_q;
    assign side_w[0]    = mode_q.per_width;
    assign side_w[1]    = mode_q.mem_width;
    assign side_inc[0]  = mode_q.per_inc;
    assign side_inc[1]  = mode_q.mem_inc;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_addr_ptr #(.AW(AW)) i_ptr (
            .clk   (clk),
            .rst   (rst),
            .load  (reload),
            .base  (side_base[s]),
            .step  (accept),
            .inc   (side_inc[s]),
            .width (side_w[s]),
            .ptr   (side_ptr[s])
        );
    end

    dma_xfer_counter #(.CW(CW)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (reload),
        .load_val (count_q),
        .dec      (accept && !last),
        .rem      (remaining),
        .last     (last)
    );

    always_comb begin
        if (mode_q.dir == DIR_MEM_TO_PER) begin
            src_addr  = side_ptr[1];
            src_width = side_w[1];
            dst_addr  = side_ptr[0];
            dst_width = side_w[0];
        end else begin
            src_addr  = side_ptr[0];
            src_width = side_w[0];
            dst_addr  = side_ptr[1];
            dst_width = side_w[1];
        end
    end

    // R9: an illegal mode never runs
    a_r9_err_idle: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);

    // R7: a non-circular pass ends the channel
    a_r7_done_stops: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !mode_q.circ) |-> !busy);

    // R8: a circular pass keeps the channel running
    a_r8_circ_runs: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && mode_q.circ) |-> busy);

    // R10: a running channel always has items left
    a_r10_no_empty_run: assert property (@(posedge clk) disable iff (rst)
        busy |-> (remaining != '0));

    // R11: stored set-up holds while running
    a_r11_base_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(per_base_q) && $stable(mem_base_q) && $stable(count_q)));

    // R6: no request while idle
    a_r6_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !beat_req);

endmodule

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_per_base = '0, cfg_mem_base = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          cfg_dir = 1'b0;
    logic [1:0]    cfg_per_width = '0, cfg_mem_width = '0;
    logic          cfg_per_inc = 1'b0, cfg_mem_inc = 1'b0;
    logic          cfg_circ = 1'b0, cfg_m2m = 1'b0;
    logic          start = 1'b0, per_req = 1'b0, beat_done = 1'b0;
    logic          busy, beat_req, xfer_done, cfg_err;
    logic [AW-1:0] src_addr, dst_addr;
    logic [1:0]    src_width, dst_width;
    logic [CW-1:0] remaining;

    int total = 0;
    int bad   = 0;

    // bench model of the stored set-up and working state
    logic [AW-1:0] m_pb, m_mb, e_pp, e_mp;
    logic [CW-1:0] m_cnt, e_rem;
    logic          m_dir, m_pi, m_mi, m_circ, m_m2m, e_busy;
    logic [1:0]    m_pw, m_mw;

    always #10 clk = ~clk;   // 50 MHz

    dma_chan_engine #(.AW(AW), .CW(CW)) i_dma_chan_engine (.*);

    function automatic logic [AW-1:0] wb(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 0; cfg_wr = 0; beat_done = 0; per_req = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e_busy = 0;
        m_pb = '0; m_mb = '0; m_cnt = '0; m_dir = 0; m_pw = 0; m_mw = 0;
        m_pi = 0; m_mi = 0; m_circ = 0; m_m2m = 0;
    endtask

    task automatic write_cfg(input logic [AW-1:0] pb, input logic [AW-1:0] mb,
                             input logic [CW-1:0] cnt, input logic dir,
                             input logic [1:0] pw, input logic [1:0] mw,
                             input logic pi, input logic mi, input logic circ, input logic m2m);
        cfg_per_base = pb; cfg_mem_base = mb; cfg_count = cnt; cfg_dir = dir;
        cfg_per_width = pw; cfg_mem_width = mw; cfg_per_inc = pi; cfg_mem_inc = mi;
        cfg_circ = circ; cfg_m2m = m2m; cfg_wr = 1'b1;
        if (!e_busy) begin
            m_pb = pb; m_mb = mb; m_cnt = cnt; m_dir = dir; m_pw = pw; m_mw = mw;
            m_pi = pi; m_mi = mi; m_circ = circ; m_m2m = m2m;
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e_pp = m_pb; e_mp = m_mb; e_rem = m_cnt; e_busy = 1'b1;
    endtask

    task automatic chk_ptrs(input string req);
        chk(req, src_addr, m_dir ? e_pp : e_mp);
        chk(req, dst_addr, m_dir ? e_mp : e_pp);
        chk(req, src_width, m_dir ? m_pw : m_mw);
        chk(req, dst_width, m_dir ? m_mw : m_pw);
        chk(req, remaining, e_rem);
    endtask

    // one cycle with the given request and beat strobe; returns the done pulse seen
    task automatic beat(input logic pr, input logic bd, output logic done_seen);
        logic acc, exp_req;
        per_req = pr; beat_done = bd;
        #1;
        exp_req = e_busy && (m_m2m || pr);
        chk("R6 beat_req", beat_req, exp_req);
        acc = exp_req && bd;
        @(negedge clk);
        per_req = 0; beat_done = 0;
        done_seen = xfer_done;
        if (acc) begin
            if (e_rem == 1) begin
                chk(m_circ ? "R8 done pulse" : "R7 done pulse", xfer_done, 1'b1);
                if (m_circ) begin
                    e_rem = m_cnt; e_pp = m_pb; e_mp = m_mb;
                end else begin
                    e_busy = 0;
                end
            end else begin
                chk("R6/R3 no done", xfer_done, 1'b0);
                e_rem = e_rem - 1;
                if (m_pi) e_pp = e_pp + wb(m_pw);
                if (m_mi) e_mp = e_mp + wb(m_mw);
            end
        end else begin
            chk("R6 ignored beat no done", xfer_done, 1'b0);
        end
        chk(m_circ ? "R8 busy" : "R7 busy", busy, e_busy);
        if (e_busy) chk_ptrs("R3/R4/R5 pointers");
    endtask

    initial begin : watchdog
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic d;
        void'($urandom(1234));
        do_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", xfer_done, 0);
        chk("R1 err", cfg_err, 0);
        chk("R1 req", beat_req, 0);

        // R2 start and R7 directed: count 3, peripheral to memory
        write_cfg(32'h4000_0000, 32'h2000_0100, 3, 1'b1, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        do_start();
        chk("R2 busy after start", busy, 1);
        chk_ptrs("R2 pointers loaded");
        // R11: write while busy is ignored
        write_cfg(32'h1111_1111, 32'h2222_2222, 9, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        // R2: start while busy ignored
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R2 start while busy", remaining, 3);
        for (int i = 0; i < 3; i++) beat(1'b1, 1'b1, d);
        chk("R7 idle after pass", busy, 0);
        @(negedge clk);
        chk("R7 one-cycle pulse", xfer_done, 0);
        do_start();
        chk("R11 old count restored", remaining, 3);
        chk("R11 old base restored", dst_addr, 32'h2000_0100);
        for (int i = 0; i < 3; i++) beat(1'b1, 1'b1, d);

        // R9: circular + memory-to-memory refused
        write_cfg(32'h10, 32'h20, 4, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R9 err set", cfg_err, 1);
        chk("R9 not busy", busy, 0);
        write_cfg(32'h10, 32'h20, 2, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        do_start();
        chk("R9 err cleared", cfg_err, 0);
        for (int i = 0; i < 2; i++) beat(1'b0, 1'b1, d);

        // R10: zero count
        write_cfg(32'h10, 32'h20, 0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        e_busy = 0;
        chk("R10 not busy", busy, 0);
        for (int i = 0; i < 4; i++) begin
            beat(1'b1, 1'b1, d);
            chk("R10 no done", d, 0);
        end

        // random passes, some circular
        for (int t = 0; t < 60; t++) begin
            logic circ, m2m;
            logic [CW-1:0] cnt;
            circ = ($urandom % 3) == 0;
            m2m  = circ ? 1'b0 : 1'($urandom % 2);
            cnt  = CW'(1 + $urandom % 5);
            write_cfg({$urandom} & 32'hFFFF_FFF0, {$urandom} & 32'hFFFF_FFF0, cnt,
                      1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      circ, m2m);
            do_start();
            chk("R2 random start", busy, 1);
            chk_ptrs("R2 random load");
            for (int c = 0; c < 40 && e_busy; c++)
                beat(1'($urandom), 1'($urandom), d);
            if (circ) do_reset();
            else chk("R7 random end", busy, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule